// File: doc/BRIEF.md
# UART Memory Read Responder

This block answers binary read requests that arrive on a serial line. It has its own bit-level UART receiver and transmitter. Both run at a fixed bit time of `CLK_HZ / BAUD` clock cycles, with 8 data bits, no parity and one stop bit. Received bytes are gathered into a 16-byte request. The request is checked, and the block then sends back the requested run of bytes from an internal byte memory, one UART frame per byte.

A request is four 32-bit words, each sent least significant byte first. In order they are the operation code, the storage selector, the start offset and the byte count. Only the read operation code is honoured. A request that is not accepted produces no output. The parser is then ready for a fresh 16-byte request.

The memory has a separate write port, so it can be loaded before any request is served.

Top module: `uart_mem_reader`

## Requirements
- R1: Transmit framing: the line rests at 1. Each byte is sent as a 0 start bit, then 8 data bits with the least significant bit first, then a 1 stop bit. Every bit lasts exactly `CLK_HZ / BAUD` clock cycles.
- R2: The receiver checks a falling edge at half a bit time. A low pulse shorter than half a bit is dropped and yields no byte. Data bits are sampled at their centres, least significant bit first.
- R3: A request is 16 received bytes, read as four little-endian 32-bit words in this order: operation code (bytes 0-3), storage selector (bytes 4-7), offset (bytes 8-11) and count (bytes 12-15).
- R4: A reply is sent only when the operation code equals 0x0000002C and the selector equals `STORE_ID` (default 0). Any other request is dropped with no output, and parsing restarts at byte 0 of the next request.
- R5: An accepted request produces exactly `count` bytes, in order, taken from memory locations `offset`, `offset+1`, and so on.
- R6: Memory addresses wrap modulo `DEPTH`. An offset at or beyond `DEPTH`, or a run that passes the last location, continues from location `offset mod DEPTH` upward with wrap-around.
- R7: A count of zero produces no output bytes.
- R8: Bytes received while a reply is in progress are ignored. The parser takes new request bytes only after the stop bit of the last reply byte has been sent.
- R9: When `mem_we_i` is high at a clock edge, `mem_wdata_i` is stored at `mem_waddr_i`, and later replies return that value.
- R10: After reset, `tx_o` is 1 and the parser is waiting for byte 0 of a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line, resting high |
| tx_o | output | 1 | Serial transmit line, resting high |
| mem_we_i | input | 1 | Memory load strobe |
| mem_waddr_i | input | $clog2(DEPTH) | Memory load address |
| mem_wdata_i | input | 8 | Memory load byte |

## Verification
Accepted requests are tried at offset zero, at a mid-memory offset, at an offset past the memory depth, and at a run that crosses the top of memory. These tell plain sequential reading apart from correct modulo wrapping. Rejected requests are each followed by a valid one: a wrong operation code, a wrong selector and a zero count. This shows they produce nothing and leave the parser aligned to the next 16-byte boundary. A short low glitch on the receive line, and junk bytes sent during a long reply, are each also followed by a valid request. A misaligned parser would then show up as a missing or wrong reply.

// File: rtl/umr_pkg.sv
package umr_pkg;
    localparam int          CMD_BYTES = 16;
    localparam logic [31:0] READ_OP   = 32'h0000_002C;

    typedef enum logic [1:0] {
        RX_IDLE, RX_START, RX_DATA, RX_STOP
    } rx_st_e;

    typedef enum logic [1:0] {
        TX_IDLE, TX_START, TX_DATA, TX_STOP
    } tx_st_e;

    typedef enum logic [2:0] {
        EN_WAIT, EN_CHECK, EN_FETCH, EN_LOAD, EN_SEND
    } eng_st_e;
endpackage

// File: rtl/umr_rx.sv
module umr_rx
    import umr_pkg::*;
#(
    parameter int DIV = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_i,
    output logic [7:0] byte_o,
    output logic       valid_o
);
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;

    typedef struct packed {
        rx_st_e        st;
        logic [CW-1:0] cnt;
        logic [2:0]    bits;
        logic [7:0]    shreg;
        logic [1:0]    sync;
        logic          valid;
    } rx_t;

    rx_t q, d;
    logic rxs;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        d.sync  = {q.sync[0], line_i};
        rxs     = q.sync[1];
        case (q.st)
            RX_IDLE: begin
                if (!rxs) begin
                    d.st  = RX_START;
                    d.cnt = '0;
                end
            end
            RX_START: begin
                if (q.cnt == CW'(HALF - 1)) begin
                    d.cnt  = '0;
                    d.bits = '0;
                    d.st   = rxs ? RX_IDLE : RX_DATA;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            RX_DATA: begin
                if (q.cnt == CW'(DIV - 1)) begin
                    d.cnt   = '0;
                    d.shreg = {rxs, q.shreg[7:1]};
                    d.bits  = q.bits + 1'b1;
                    if (q.bits == 3'd7) d.st = RX_STOP;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            RX_STOP: begin
                if (q.cnt == CW'(DIV - 1)) begin
                    d.valid = rxs;
                    d.st    = RX_IDLE;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= RX_IDLE;
            q.sync  <= 2'b11;
        end else begin
            q <= d;
        end
    end

    assign byte_o  = q.shreg;
    assign valid_o = q.valid;
endmodule

// File: rtl/umr_tx.sv
module umr_tx
    import umr_pkg::*;
#(
    parameter int DIV = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] data_i,
    output logic       line_o,
    output logic       busy_o,
    output logic       done_o
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

    typedef struct packed {
        tx_st_e        st;
        logic [CW-1:0] cnt;
        logic [2:0]    bits;
        logic [7:0]    shreg;
        logic          line;
        logic          done;
    } tx_t;

    tx_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            TX_IDLE: begin
                d.line = 1'b1;
                if (start_i) begin
                    d.shreg = data_i;
                    d.st    = TX_START;
                    d.line  = 1'b0;
                    d.cnt   = '0;
                end
            end
            TX_START: begin
                if (q.cnt == CW'(DIV - 1)) begin
                    d.cnt  = '0;
                    d.bits = '0;
                    d.st   = TX_DATA;
                    d.line = q.shreg[0];
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            TX_DATA: begin
                if (q.cnt == CW'(DIV - 1)) begin
                    d.cnt = '0;
                    if (q.bits == 3'd7) begin
                        d.st   = TX_STOP;
                        d.line = 1'b1;
                    end else begin
                        d.bits  = q.bits + 1'b1;
                        d.shreg = q.shreg >> 1;
                        d.line  = q.shreg[1];
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            TX_STOP: begin
                if (q.cnt == CW'(DIV - 1)) begin
                    d.cnt  = '0;
                    d.st   = TX_IDLE;
                    d.done = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= TX_IDLE;
            q.line <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign line_o = q.line;
    assign busy_o = (q.st != TX_IDLE);
    assign done_o = q.done;
endmodule

// File: rtl/umr_mem.sv
module umr_mem #(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic          re_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);
    logic [7:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) store[waddr_i] <= wdata_i;
        if (re_i) rdata_o <= store[raddr_i];
    end
endmodule

// File: rtl/umr_engine.sv
module umr_engine
    import umr_pkg::*;
#(
    parameter int          AW       = 10,
    parameter logic [31:0] STORE_ID = 32'h0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    rx_byte_i,
    input  logic          rx_valid_i,
    input  logic          tx_done_i,
    input  logic [7:0]    rd_data_i,
    output logic          rd_en_o,
    output logic [AW-1:0] rd_addr_o,
    output logic          tx_start_o,
    output logic [7:0]    tx_byte_o
);
    localparam int CMD_W = CMD_BYTES * 8;

    typedef struct packed {
        eng_st_e          st;
        logic [3:0]       nb;
        logic [CMD_W-1:0] cmd;
        logic [AW-1:0]    addr;
        logic [31:0]      remain;
    } eng_t;

    eng_t q, d;
    logic [31:0] f_op, f_id, f_off, f_cnt;

    always_comb begin
        d     = q;
        f_op  = q.cmd[31:0];
        f_id  = q.cmd[63:32];
        f_off = q.cmd[95:64];
        f_cnt = q.cmd[127:96];
        case (q.st)
            EN_WAIT: begin
                if (rx_valid_i) begin
                    d.cmd = {rx_byte_i, q.cmd[CMD_W-1:8]};
                    d.nb  = q.nb + 1'b1;
                    if (q.nb == 4'(CMD_BYTES - 1)) d.st = EN_CHECK;
                end
            end
            EN_CHECK: begin
                if (f_op == READ_OP && f_id == STORE_ID && f_cnt != 32'd0) begin
                    d.addr   = f_off[AW-1:0];
                    d.remain = f_cnt;
                    d.st     = EN_FETCH;
                end else begin
                    d.st = EN_WAIT;
                end
            end
            EN_FETCH: d.st = EN_LOAD;
            EN_LOAD: begin
                d.addr   = q.addr + 1'b1;
                d.remain = q.remain - 1'b1;
                d.st     = EN_SEND;
            end
            EN_SEND: begin
                if (tx_done_i) d.st = (q.remain == 32'd0) ? EN_WAIT : EN_FETCH;
            end
            default: d.st = EN_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= EN_WAIT;
        end else begin
            q <= d;
        end
    end

    assign rd_en_o    = (q.st == EN_FETCH);
    assign rd_addr_o  = q.addr;
    assign tx_start_o = (q.st == EN_LOAD);
    assign tx_byte_o  = rd_data_i;
endmodule

// File: rtl/uart_mem_reader.sv
module uart_mem_reader #(
    parameter int          CLK_HZ   = 100_000_000,
    parameter int          BAUD     = 9600,
    parameter int          DEPTH    = 1024,
    parameter logic [31:0] STORE_ID = 32'h0,
    localparam int         AW       = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_i,
    output logic          tx_o,
    input  logic          mem_we_i,
    input  logic [AW-1:0] mem_waddr_i,
    input  logic [7:0]    mem_wdata_i
);
    localparam int DIV = CLK_HZ / BAUD;

    logic [7:0]    rx_byte, tx_byte, rd_data;
    logic          rx_valid, tx_start, tx_busy, tx_done, rd_en;
    logic [AW-1:0] rd_addr;

    umr_rx #(.DIV(DIV)) u_rx (
        .clk(clk), .rst_n(rst_n), .line_i(rx_i),
        .byte_o(rx_byte), .valid_o(rx_valid)
    );

    umr_engine #(.AW(AW), .STORE_ID(STORE_ID)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .rx_byte_i(rx_byte), .rx_valid_i(rx_valid),
        .tx_done_i(tx_done), .rd_data_i(rd_data),
        .rd_en_o(rd_en), .rd_addr_o(rd_addr),
        .tx_start_o(tx_start), .tx_byte_o(tx_byte)
    );

    umr_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk(clk), .we_i(mem_we_i), .waddr_i(mem_waddr_i), .wdata_i(mem_wdata_i),
        .re_i(rd_en), .raddr_i(rd_addr), .rdata_o(rd_data)
    );

    umr_tx #(.DIV(DIV)) u_tx (
        .clk(clk), .rst_n(rst_n), .start_i(tx_start), .data_i(tx_byte),
        .line_o(tx_o), .busy_o(tx_busy), .done_o(tx_done)
    );
endmodule

// File: rtl/umr_checker.sv
module umr_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_o,
    input logic tx_busy,
    input logic tx_start,
    input logic tx_done,
    input logic rd_en
);
    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> tx_o);

    // R1
    start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_o);

    // R5
    start_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> !tx_busy);

    // R5
    fetch_then_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> tx_start);

    // R8
    no_fetch_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy && !tx_done |-> !rd_en);
endmodule

bind uart_mem_reader umr_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tx_o(tx_o), .tx_busy(tx_busy),
    .tx_start(tx_start), .tx_done(tx_done), .rd_en(rd_en)
);

// File: tb/uart_mem_reader_test.sv
module uart_mem_reader_test;
    localparam int DIV   = 16;
    localparam int CLKHZ = 9600 * DIV;
    localparam int DEPTH = 256;
    localparam int AW    = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_i = 1'b1;
    logic tx_o;
    logic mem_we_i = 1'b0;
    logic [AW-1:0] mem_waddr_i = '0;
    logic [7:0] mem_wdata_i = '0;

    always #5 clk = ~clk;

    uart_mem_reader #(.CLK_HZ(CLKHZ), .BAUD(9600), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .tx_o(tx_o),
        .mem_we_i(mem_we_i), .mem_waddr_i(mem_waddr_i), .mem_wdata_i(mem_wdata_i)
    );

    int total = 0;
    int bad   = 0;
    string cur_req = "R10";
    byte unsigned mem_model [DEPTH];
    byte unsigned exp_q [$];
    bit done_flag = 0;

    task automatic check(bit ok, string req, string what, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, expv);
        end
    endtask

    // line monitor: decodes every byte on tx_o and compares with the model queue
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && tx_o == 1'b0) begin
                logic [7:0] got;
                logic ok_frame;
                ok_frame = 1'b1;
                repeat (DIV / 2) @(negedge clk);
                if (tx_o != 1'b0) ok_frame = 1'b0;
                for (int b = 0; b < 8; b++) begin
                    repeat (DIV) @(negedge clk);
                    got[b] = tx_o;
                end
                repeat (DIV) @(negedge clk);
                check(tx_o == 1'b1 && ok_frame, "R1", "frame start/stop level",
                      {30'd0, ok_frame, tx_o}, 3);
                if (exp_q.size() == 0) begin
                    check(1'b0, cur_req, "unexpected reply byte", got, 0);
                end else begin
                    byte unsigned e;
                    e = exp_q.pop_front();
                    check(got == e, cur_req, "reply byte", got, e);
                end
            end
        end
    end

    task automatic send_byte(byte unsigned v);
        rx_i = 1'b0;
        repeat (DIV) @(negedge clk);
        for (int b = 0; b < 8; b++) begin
            rx_i = v[b];
            repeat (DIV) @(negedge clk);
        end
        rx_i = 1'b1;
        repeat (DIV) @(negedge clk);
    endtask

    task automatic send_word(int unsigned w);
        for (int k = 0; k < 4; k++) send_byte(byte'(w >> (8 * k)));
    endtask

    // R3: four little-endian words: op, id, offset, count
    task automatic send_req(int unsigned op, int unsigned id, int unsigned off, int unsigned cnt);
        if (op == 32'h2C && id == 0) begin
            for (int unsigned i = 0; i < cnt; i++) exp_q.push_back(mem_model[(off + i) % DEPTH]);
        end
        send_word(op);
        send_word(id);
        send_word(off);
        send_word(cnt);
    endtask

    task automatic settle(string req);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (30 * DIV) @(negedge clk);
        check(exp_q.size() == 0, req, "pending bytes after reply", exp_q.size(), 0);
    endtask

    task automatic load(int a, byte unsigned v);
        mem_we_i = 1'b1;
        mem_waddr_i = AW'(a);
        mem_wdata_i = v;
        @(negedge clk);
        mem_we_i = 1'b0;
        mem_model[a] = v;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done_flag) begin
            total++;
            bad++;
            $display("FAIL watchdog expired during %s", cur_req);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(tx_o == 1'b1, "R10", "tx line in reset", tx_o, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_o == 1'b1, "R10", "tx line after reset", tx_o, 1);

        // R9: preload via the side port
        for (int a = 0; a < DEPTH; a++) load(a, byte'(a * 7 + 3));

        cur_req = "R5";
        send_req(32'h2C, 0, 0, 4);
        settle("R5");

        send_req(32'h2C, 0, 100, 16);
        settle("R5");

        cur_req = "R9";
        load(37, 8'hA5);
        send_req(32'h2C, 0, 36, 3);
        settle("R9");

        cur_req = "R4";
        send_req(32'h2D, 0, 0, 4);
        settle("R4");
        send_req(32'h2C, 1, 0, 4);
        settle("R4");
        send_req(32'h2C, 0, 50, 2);
        settle("R4");

        cur_req = "R7";
        send_req(32'h2C, 0, 10, 0);
        settle("R7");
        send_req(32'h2C, 0, 11, 1);
        settle("R7");

        cur_req = "R6";
        send_req(32'h2C, 0, DEPTH - 3, 6);
        settle("R6");
        send_req(32'h2C, 0, 32'h0001_0005, 3);
        settle("R6");

        cur_req = "R2";
        rx_i = 1'b0;
        repeat (3) @(negedge clk);
        rx_i = 1'b1;
        repeat (2 * DIV) @(negedge clk);
        send_req(32'h2C, 0, 200, 4);
        settle("R2");

        cur_req = "R8";
        send_req(32'h2C, 0, 64, 16);
        send_byte(8'h2C);
        send_byte(8'h00);
        send_byte(8'h11);
        settle("R8");
        send_req(32'h2C, 0, 9, 2);
        settle("R8");

        done_flag = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule